// File: doc/BRIEF.md
# S/PDIF Channel-Status and Validity Controller

This block sits beside an S/PDIF transmitter and supplies two things for every frame: the channel-status bit for the current position in the 192-frame status block, and the validity bit that goes into both subframes. The transmitter owns line coding, preambles and sample packing. It reports each finished frame on a strobe. The controller keeps the frame position, presents the matching channel-status bit and raises a block-start flag while the position is frame 0.

Software sets a 16-bit control word through a simple write/read port. The word holds the professional/consumer select, the non-PCM flag, the copyright flag, the pre-emphasis select, a 7-bit category code, a generation-level bit, a 2-bit rate code and a validity override in bit 15. While the transmitter is enabled, every field except the validity override is frozen, so the status block stays consistent for the whole transmission. The sampling-frequency status bits are derived from the rate code when the enable input rises and are held from then on.

Top module: `spdif_cs_ctrl`

## Requirements
- R1: After reset the control word reads 0x2000, which is rate code 10 with every other field 0.
- R2: With the transmitter disabled, a write stores all bits of wr_data except bit 14. rd_data returns the stored word from the cycle after the write, and bit 14 always reads 0.
- R3: With tx_en high, a write changes only bit 15. Bits 14:0 keep their previous values.
- R4: When bit 15 is 1, valid_bit is 1 whatever err_in and force_valid are.
- R5: When bit 15 is 0 and force_valid is 1, valid_bit is 0 whatever err_in is.
- R6: When bit 15 is 0 and force_valid is 0, valid_bit equals err_in.
- R7: While tx_en is high, each cycle with frame_stb high moves the frame index forward by one, and the index returns to 0 after frame 191. While tx_en is low, the index is 0. cs_bit gives channel-status bit n while the index is n.
- R8: Channel-status bits 0, 1, 2 and 3 carry control bits 0 (professional), 1 (non-PCM), 2 (copyright) and 3 (pre-emphasis). Bits 8+k for k=0..6 carry control bit 4+k (category code), bit 15 carries control bit 11 (generation level), and every position not listed in R8 or R9 is 0.
- R9: On the cycle tx_en rises, the rate code in control bits 13:12 is captured. Code 00 leaves status bits 24 to 27 at 0. Code 10 sets status bit 25. Codes 01 and 11 set status bit 24. The captured value holds while tx_en stays high.
- R10: blk_start is 1 exactly when tx_en is high and the frame index is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 16 | Control-word write data |
| rd_data | output | 16 | Stored control word |
| tx_en | input | 1 | Transmitter enabled |
| err_in | input | 1 | Error/mute condition from the data source |
| force_valid | input | 1 | Mark samples valid while override is clear |
| frame_stb | input | 1 | One-cycle pulse at the end of each frame |
| cs_bit | output | 1 | Channel-status bit for the current frame |
| valid_bit | output | 1 | Validity bit for both subframes |
| blk_start | output | 1 | Current frame is the first of the block |

## Verification
The assertions assume that frame_stb is a single-cycle pulse that only has meaning while tx_en is high. They also assume that tx_en is held for many cycles once it is raised, so every enable edge is followed by a stable capture. The stimulus writes the control word only at clock-safe moments. It raises tx_en only after the word is settled, steps the frame strobe one pulse at a time through whole 192-frame blocks, and drops tx_en between configurations. Validity inputs are changed away from clock edges and checked combinationally across all eight combinations.

// File: rtl/spdif_cs_pkg.sv
package spdif_cs_pkg;

    localparam int CTRL_W = 16;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h2000;
    localparam logic [CTRL_W-1:0] UNLOCKED_MASK = 16'hBFFF;

    typedef struct packed {
        logic       vforce_inv;
        logic       spare;
        logic [1:0] rate;
        logic       gen_lvl;
        logic [6:0] category;
        logic       emph;
        logic       copyright;
        logic       nonpcm;
        logic       pro;
    } ctrl_t;

    typedef logic [1:0] fs_t;   // [0] -> status bit 24, [1] -> status bit 25

    function automatic fs_t rate_to_fs(input logic [1:0] rate);
        case (rate)
            2'b00:   rate_to_fs = 2'b00;
            2'b10:   rate_to_fs = 2'b10;
            default: rate_to_fs = 2'b01;
        endcase
    endfunction

    function automatic logic status_bit(input ctrl_t c, input fs_t fs, input logic [7:0] pos);
        logic b;
        b = 1'b0;
        if (pos == 8'd0)                        b = c.pro;
        else if (pos == 8'd1)                   b = c.nonpcm;
        else if (pos == 8'd2)                   b = c.copyright;
        else if (pos == 8'd3)                   b = c.emph;
        else if (pos >= 8'd8 && pos <= 8'd14)   b = c.category[3'(pos - 8'd8)];
        else if (pos == 8'd15)                  b = c.gen_lvl;
        else if (pos == 8'd24 || pos == 8'd25)  b = fs[1'(pos - 8'd24)];
        return b;
    endfunction

endpackage

// File: rtl/cs_ctrl_reg.sv
module cs_ctrl_reg
    import spdif_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              tx_en,
    output ctrl_t             ctrl
);

    ctrl_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= ctrl_t'(CTRL_RESET);
        end else if (wr_en) begin
            if (!tx_en) q <= ctrl_t'(wr_data & UNLOCKED_MASK);
            else        q.vforce_inv <= wr_data[CTRL_W-1];
        end
    end

    assign ctrl = q;

    // R3: locked fields are untouched while the transmitter runs
    assert_lock_hold_R3: assert property (@(posedge clk) disable iff (rst)
        tx_en |=> $stable(q[CTRL_W-2:0]));

    // R2: the spare bit never becomes set
    assert_spare_zero_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !q.spare);

endmodule

// File: rtl/cs_frame_seq.sv
module cs_frame_seq
    import spdif_cs_pkg::*;
#(
    parameter int FRAMES = 192
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tx_en,
    input  logic  frame_stb,
    input  ctrl_t ctrl,
    output logic  cs_bit,
    output logic  blk_start
);

    localparam int IDX_W = $clog2(FRAMES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

    logic [IDX_W-1:0] idx;
    logic             tx_q;
    fs_t              fs;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            tx_q <= 1'b0;
            fs   <= '0;
        end else begin
            tx_q <= tx_en;
            if (tx_en && !tx_q) fs <= rate_to_fs(ctrl.rate);
            if (!tx_en)         idx <= '0;
            else if (frame_stb) idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    assign cs_bit    = status_bit(ctrl, fs, 8'(idx));
    assign blk_start = tx_en && (idx == '0);

    // R7: index wraps to zero after the final frame
    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_en && frame_stb && idx == LAST) |=> (idx == '0));

    // R7: index is parked while disabled
    assert_park_R7: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (idx == '0));

    // R7: index stays in range
    assert_range_R7: assert property (@(posedge clk) disable iff (rst)
        idx <= LAST);

    // R9: captured rate bits hold while transmitting
    assert_fs_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_en && tx_q) |=> $stable(fs));

endmodule

// File: rtl/cs_validity.sv
module cs_validity
    import spdif_cs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  err_in,
    input  logic  force_valid,
    output logic  valid_bit
);

    always_comb begin
        if (ctrl.vforce_inv)  valid_bit = 1'b1;
        else if (force_valid) valid_bit = 1'b0;
        else                  valid_bit = err_in;
    end

    assert_inv_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl.vforce_inv |-> valid_bit);

    assert_fvalid_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.vforce_inv && force_valid) |-> !valid_bit);

    assert_err_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.vforce_inv && !force_valid) |-> (valid_bit == err_in));

endmodule

// File: rtl/spdif_cs_ctrl.sv
module spdif_cs_ctrl
    import spdif_cs_pkg::*;
#(
    parameter int FRAMES = 192
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        tx_en,
    input  logic        err_in,
    input  logic        force_valid,
    input  logic        frame_stb,
    output logic        cs_bit,
    output logic        valid_bit,
    output logic        blk_start
);

    ctrl_t ctrl;

    cs_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .tx_en   (tx_en),
        .ctrl    (ctrl)
    );

    cs_frame_seq #(.FRAMES(FRAMES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .frame_stb (frame_stb),
        .ctrl      (ctrl),
        .cs_bit    (cs_bit),
        .blk_start (blk_start)
    );

    cs_validity u_val (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .err_in      (err_in),
        .force_valid (force_valid),
        .valid_bit   (valid_bit)
    );

    assign rd_data = ctrl;

    // R10: block start only while enabled
    assert_blk_R10: assert property (@(posedge clk) disable iff (rst)
        blk_start |-> tx_en);

endmodule

// File: tb/tb_spdif_cs_ctrl.sv
module tb_spdif_cs_ctrl;

    localparam int CLK_P = 10;
    localparam int NF = 192;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        tx_en = 1'b0;
    logic        err_in = 1'b0;
    logic        force_valid = 1'b0;
    logic        frame_stb = 1'b0;
    logic        cs_bit, valid_bit, blk_start;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    spdif_cs_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tx_en(tx_en), .err_in(err_in), .force_valid(force_valid), .frame_stb(frame_stb),
        .cs_bit(cs_bit), .valid_bit(valid_bit), .blk_start(blk_start)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected channel-status bit from R8/R9, using the word present at enable
    function automatic logic exp_cs(input logic [15:0] w, input int n);
        if (n < 4) return w[n];
        if (n >= 8 && n <= 14) return w[n - 4];
        if (n == 15) return w[11];
        if (n == 24) return (w[13:12] == 2'b01) || (w[13:12] == 2'b11);
        if (n == 25) return w[13:12] == 2'b10;
        return 1'b0;
    endfunction

    task automatic write_word(input logic [15:0] w);
        wr_data = w; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_block(input logic [15:0] w, input string tag);
        tx_en = 1'b1;
        @(negedge clk);
        for (int n = 0; n < NF; n++) begin
            check({tag, " R7 R8 R9 cs"}, 16'(cs_bit), 16'(exp_cs(w, n)));
            check({tag, " R10 blk"}, 16'(blk_start), 16'(n == 0));
            frame_stb = 1'b1;
            @(negedge clk);
            frame_stb = 1'b0;
            @(negedge clk);
        end
        check({tag, " R7 wrap"}, 16'(blk_start), 16'd1);
        check({tag, " R7 wrap cs"}, 16'(cs_bit), 16'(exp_cs(w, 0)));
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] words [5];
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset word", rd_data, 16'h2000);
        check("R10 blk idle", 16'(blk_start), 16'd0);

        // R2: bit 14 dropped, rest stored
        write_word(16'hFFFF);
        check("R2 readback", rd_data, 16'hBFFF);
        write_word(16'h4000);
        check("R2 bit14", rd_data, 16'h0000);

        // R4 R5 R6: all validity combinations
        for (int v = 0; v < 2; v++) begin
            write_word(v[0] ? 16'h8000 : 16'h0000);
            for (int k = 0; k < 4; k++) begin
                force_valid = k[1]; err_in = k[0];
                #1;
                if (v[0])      check("R4 valid", 16'(valid_bit), 16'd1);
                else if (k[1]) check("R5 valid", 16'(valid_bit), 16'd0);
                else           check("R6 valid", 16'(valid_bit), 16'(k[0]));
            end
            @(negedge clk);
        end
        force_valid = 1'b0; err_in = 1'b0;

        words[0] = 16'h2000;
        words[1] = 16'h0F5F;
        words[2] = 16'h1AAA;
        words[3] = 16'h3555;
        words[4] = 16'h27F0;
        for (int i = 0; i < 5; i++) begin
            tx_en = 1'b0;
            @(negedge clk);
            write_word(words[i]);
            run_block(words[i], $sformatf("blk%0d", i));
        end

        // R3: locked while enabled, only bit 15 follows
        write_word(16'hFFFF);
        check("R3 lock set", rd_data, 16'h8000 | words[4]);
        write_word(16'h0000);
        check("R3 lock clear", rd_data, words[4]);
        // status still from stored word and captured rate (R9 hold)
        check("R9 hold idx0", 16'(cs_bit), 16'(exp_cs(words[4], 0)));

        tx_en = 1'b0;
        @(negedge clk);
        check("R7 park", 16'(blk_start), 16'd0);
        write_word(16'h0003);
        check("R3 unlocked", rd_data, 16'h0003);
        run_block(16'h0003, "final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule